// File: doc/BRIEF.md
# Banked Single-Port Sample Delay Line

This block returns, for every accepted input sample, the sample that was accepted a chosen number of strobes earlier. The delay can be a quarter, a half or all of an 8192-word store (2048, 4096 or 8192 samples). It serves correlation engines that compare a stream with a copy of itself one symbol length back, and that may have to try several symbol lengths one after the other.

The store is eight banks of 1024 words. Each bank has a single port, and the banks are arranged as one circular buffer. The write pointer always runs around the whole 8192-word space, whatever delay is selected. A change of delay therefore only moves the read offset. Samples already stored stay valid, and the new delay gives correct data from its first sample on.

Each accepted sample takes two clock cycles. In the first cycle the old word is read, and in the second cycle the new word is written, so a bank never sees a read and a write in the same cycle. Per-bank enable outputs show which banks must be powered. At most two banks are powered at any moment: the bank being read and the bank being written.

Top module: `dl_banked_delay`

## Requirements
- R1: While reset is held and right after it is released, `delayedValid` is 0, `delayedOut` is 0 and `bankEnable` is all zeros.
- R2: A strobe accepted at a rising edge gives a one-cycle `delayedValid` pulse. The pulse is high in the cycle after the second rising edge that follows the accepting edge. `delayedValid` is never high in two consecutive cycles.
- R3: With `modeSel` = 2'b00, `delayedOut` equals the sample accepted 2048 accepted strobes earlier.
- R4: With `modeSel` = 2'b01, `delayedOut` equals the sample accepted 4096 accepted strobes earlier.
- R5: With `modeSel` = 2'b10 or 2'b11, `delayedOut` equals the sample accepted 8192 accepted strobes earlier. The read and the write then hit the same word, and the read returns the old value.
- R6: `modeSel` is sampled only when a strobe is accepted. After a change of delay, the first output already has the new delay, with no refill.
- R7: A strobe in the cycle directly after an accepted strobe (the read cycle) is ignored: it produces no output and does not advance the buffer. A strobe in the next cycle (the write cycle) is accepted, so one sample every two cycles is sustained.
- R8: `bankEnable` never has more than two bits set, and it is all zeros when no sample is in flight.
- R9: The write position wraps from word 8191 to word 0 for every delay setting, and outputs stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStrobe | input | 1 | Offers `sampleIn` for acceptance |
| sampleIn | input | DATA_W | Sample to store |
| modeSel | input | 2 | Delay: 00 = 2048, 01 = 4096, 1x = 8192 |
| delayedOut | output | DATA_W | Delayed sample |
| delayedValid | output | 1 | One-cycle pulse marking `delayedOut` |
| bankEnable | output | 8 | Power enable, one bit per bank |

## Verification
Each accepted strobe produces its result exactly three clock-counter steps after the falling edge at which the bench drove it. That is one edge to accept the strobe, one for the read and one for the write and output register. The driver stamps this due cycle into each scoreboard entry, and the monitor checks both the cycle and the value at the falling edge where the pulse appears. Expected values are recomputed from the acceptance index and the selected delay. Results whose source sample was never written are checked for timing only. The ignored strobe in the read cycle is shown through the outputs that follow it: it creates no pulse, and the delays of later samples do not shift.

// File: rtl/dl_banked_pkg.sv
`timescale 1ns/1ps
package dl_banked_pkg;
  parameter int unsigned BANK_COUNT = 8;
  parameter int unsigned BANK_DEPTH = 1024;
  localparam int unsigned TOTAL_DEPTH = BANK_COUNT * BANK_DEPTH;
  localparam int unsigned PTR_W  = $clog2(TOTAL_DEPTH);
  localparam int unsigned WORD_W = $clog2(BANK_DEPTH);
  localparam int unsigned BANK_W = $clog2(BANK_COUNT);

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [BANK_COUNT-1:0] bankPwr;
    logic [BANK_COUNT-1:0] bankAccess;
    logic                  writeEn;
    logic [WORD_W-1:0]     wordAddr;
    logic                  holdLoad;
    logic                  outLoad;
    logic [BANK_W-1:0]     rdBank;
  } dl_strobe_t;
endpackage

// File: rtl/dl_sp_bank.sv
`timescale 1ns/1ps
module dl_sp_bank #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // one port: either a write or a registered read per enabled cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/dl_ctrl.sv
`timescale 1ns/1ps
module dl_ctrl
  import dl_banked_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleStrobe,
  input  logic [1:0] modeSel,
  output dl_strobe_t strb
);
  phase_t            phase;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  nextWr;
  logic              accept;
  logic [BANK_W-1:0] rdBankIdx;
  logic [BANK_W-1:0] wrBankIdx;
  logic [BANK_COUNT-1:0] rdOneHot;
  logic [BANK_COUNT-1:0] wrOneHot;

  // delay modulo the full store: full span wraps to zero offset
  function automatic logic [PTR_W-1:0] spanFor(input logic [1:0] m);
    case (m)
      2'b00:   return PTR_W'(TOTAL_DEPTH / 4);
      2'b01:   return PTR_W'(TOTAL_DEPTH / 2);
      default: return '0;
    endcase
  endfunction

  assign accept    = sampleStrobe && (phase != PH_READ);
  assign nextWr    = (phase == PH_WRITE) ? wrPtr + PTR_W'(1) : wrPtr;
  assign rdBankIdx = rdPtr[PTR_W-1 -: BANK_W];
  assign wrBankIdx = wrPtr[PTR_W-1 -: BANK_W];
  assign rdOneHot  = BANK_COUNT'(1) << rdBankIdx;
  assign wrOneHot  = BANK_COUNT'(1) << wrBankIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (phase == PH_WRITE) wrPtr <= nextWr;
      if (accept) rdPtr <= nextWr - spanFor(modeSel);
      case (phase)
        PH_IDLE:  phase <= accept ? PH_READ : PH_IDLE;
        PH_READ:  phase <= PH_WRITE;
        PH_WRITE: phase <= accept ? PH_READ : PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.holdLoad = accept;
    strb.rdBank   = rdBankIdx;
    case (phase)
      PH_READ: begin
        strb.bankPwr    = rdOneHot | wrOneHot;
        strb.bankAccess = rdOneHot;
        strb.wordAddr   = rdPtr[WORD_W-1:0];
      end
      PH_WRITE: begin
        strb.bankPwr    = rdOneHot | wrOneHot;
        strb.bankAccess = wrOneHot;
        strb.writeEn    = 1'b1;
        strb.wordAddr   = wrPtr[WORD_W-1:0];
        strb.outLoad    = 1'b1;
      end
      default: ;
    endcase
  end

  p_read_then_write_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ) |=> (phase == PH_WRITE));
  p_ptr_single_step_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(wrPtr) |-> ((wrPtr - $past(wrPtr)) == PTR_W'(1)));
  p_ptr_moves_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE) |=> !$stable(wrPtr));
  p_power_limit_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(strb.bankPwr) <= 2);
endmodule

// File: rtl/dl_datapath.sv
`timescale 1ns/1ps
module dl_datapath
  import dl_banked_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  dl_strobe_t        strb,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] delayedOut,
  output logic              delayedValid
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] rdData [BANK_COUNT];

  for (genvar g = 0; g < BANK_COUNT; g++) begin : g_bank
    dl_sp_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk  (clk),
      .en   (strb.bankAccess[g]),
      .we   (strb.writeEn),
      .addr (strb.wordAddr),
      .wdata(holdReg),
      .rdata(rdData[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg      <= '0;
      delayedOut   <= '0;
      delayedValid <= 1'b0;
    end else begin
      if (strb.holdLoad) holdReg <= sampleIn;
      delayedValid <= strb.outLoad;
      if (strb.outLoad) delayedOut <= rdData[strb.rdBank];
    end
  end

  p_single_access_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.bankAccess));
  p_access_powered_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.bankAccess & ~strb.bankPwr) == '0);
  p_write_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.writeEn && strb.bankAccess != '0) |-> ($past(strb.bankAccess) != '0 && !$past(strb.writeEn)));
endmodule

// File: rtl/dl_banked_delay.sv
`timescale 1ns/1ps
module dl_banked_delay
  import dl_banked_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sampleStrobe,
  input  logic [DATA_W-1:0]     sampleIn,
  input  logic [1:0]            modeSel,
  output logic [DATA_W-1:0]     delayedOut,
  output logic                  delayedValid,
  output logic [BANK_COUNT-1:0] bankEnable
);
  dl_strobe_t strb;

  dl_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleStrobe(sampleStrobe),
    .modeSel     (modeSel),
    .strb        (strb)
  );

  dl_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .sampleIn    (sampleIn),
    .delayedOut  (delayedOut),
    .delayedValid(delayedValid)
  );

  assign bankEnable = strb.bankPwr;

  p_valid_gap_r2: assert property (@(posedge clk) disable iff (rst)
    delayedValid |=> !delayedValid);
  p_dark_after_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!sampleStrobe) && delayedValid) |-> (bankEnable == '0));
endmodule

// File: tb/dl_banked_delay_test.sv
`timescale 1ns/1ps
module dl_banked_delay_test;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          sampleStrobe;
  logic [DW-1:0] sampleIn;
  logic [1:0]    modeSel;
  logic [DW-1:0] delayedOut;
  logic          delayedValid;
  logic [7:0]    bankEnable;

  always #2.5 clk = ~clk;

  dl_banked_delay #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe), .sampleIn(sampleIn),
    .modeSel(modeSel), .delayedOut(delayedOut), .delayedValid(delayedValid),
    .bankEnable(bankEnable)
  );

  typedef struct {
    int          due;
    logic        known;
    logic [11:0] val;
    int          tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int acc = 0;
  int nChecks = 0;
  int nFail = 0;
  int maxPwr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tagName(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6";
      7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  function automatic logic [11:0] valOf(input int i);
    return 12'((i * 37 + (i / 4096) * 1111 + (i / 8192) * 555) % 4096);
  endfunction

  function automatic int spanOf(input logic [1:0] m);
    case (m)
      2'b00:   return 2048;
      2'b01:   return 4096;
      default: return 8192;
    endcase
  endfunction

  task automatic check(input bit ok, input int tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tagName(tag), act, exp, cyc);
    end
  endtask

  task automatic push(input logic [1:0] m, input int tag);
    exp_t e;
    e.due   = cyc + 3;
    e.known = (acc >= spanOf(m));
    e.val   = e.known ? valOf(acc - spanOf(m)) : 12'd0;
    e.tag   = tag;
    q.push_back(e);
  endtask

  // drive at a falling edge, one sample every two cycles
  task automatic send(input logic [1:0] m, input int tag);
    sampleStrobe = 1'b1;
    sampleIn     = valOf(acc);
    modeSel      = m;
    push(m, tag);
    acc++;
    @(negedge clk);
    sampleStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(bankEnable) > maxPwr) maxPwr = $countones(bankEnable);
      if (delayedValid) begin
        if (q.size() == 0) begin
          check(1'b0, 2, 1, 0); // R2: pulse with nothing pending
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.due, 2, cyc, e.due); // R2 latency
          if (e.known) check(delayedOut == e.val, e.tag, int'(delayedOut), int'(e.val));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R2: watchdog expired, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    sampleStrobe = 1'b0;
    sampleIn = '0;
    modeSel = 2'b00;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(delayedValid == 1'b0, 1, int'(delayedValid), 0);
    check(bankEnable == 8'h00, 1, int'(bankEnable), 0);
    check(delayedOut == '0, 1, int'(delayedOut), 0);
    rst = 1'b0;
    @(negedge clk);
    check(bankEnable == 8'h00, 1, int'(bankEnable), 0);

    // R5/R9: longest delay, fill and run across the pointer wrap, some gaps
    for (int i = 0; i < 8500; i++) begin
      send(2'b10, 9);
      if (i % 7 == 3) @(negedge clk);
    end
    // R3 with R6 on the first sample after the switch
    for (int i = 0; i < 400; i++) send(2'b00, (i == 0) ? 6 : 3);
    // R4 with R6 on the first sample
    for (int i = 0; i < 400; i++) send(2'b01, (i == 0) ? 6 : 4);

    // R7: strobe held into the read cycle; second one must be dropped
    sampleStrobe = 1'b1;
    sampleIn = valOf(acc);
    modeSel = 2'b01;
    push(2'b01, 7);
    acc++;
    @(negedge clk);
    sampleIn = 12'hABC;
    @(negedge clk);
    sampleStrobe = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) send(2'b01, 7);

    // R5 through the 2'b11 encoding, R6 on the switch
    for (int i = 0; i < 300; i++) send(2'b11, (i == 0) ? 6 : 5);

    repeat (10) @(negedge clk);
    check(q.size() == 0, 2, q.size(), 0);          // R2: every result arrived
    check(maxPwr <= 2, 8, maxPwr, 2);               // R8: at most two banks
    check(bankEnable == 8'h00, 8, int'(bankEnable), 0); // R8: idle dark
    summary();
    $finish;
  end
endmodule